// File: doc/BRIEF.md
# One-Time-Programmable ID Register with Command Interface

This block holds a 128-bit identification register behind a 16-bit write bus. The lower half of the register is a 64-bit factory identity. It comes from a parameter and can never change. The upper half is a 64-bit user field. It starts blank, with every bit at 1, and is programmed one 16-bit word at a time. A user lock bit closes the user field against any further programming. The non-volatile cells are modelled with flip-flops, so a reset restores the blank state of the model.

A small command decoder looks at the low byte of each bus write. Code 90h selects configuration-read mode. In that mode the read port returns register words at fixed offsets from `CFG_BASE`. Code FFh selects array-read mode, where the read port passes through the word supplied by the memory array outside this block. Programming takes two writes. The first write carries C0h and arms the decoder. The next write supplies an address and a data word and is always taken as the program operation, never as a command.

A program operation can only clear bits. A program aimed at the factory words, at a user word while the lock is closed, or at an address that is not defined is refused. A refused program sets a sticky error flag.

Top module: `otp_id_reg`

## Requirements
- R1: After reset the block is in array-read mode, no program is armed, the error flag is 0, all 64 user bits are 1 and the user lock is open.
- R2: A write whose low byte is 90h enters configuration-read mode, and one whose low byte is FFh enters array-read mode. The upper byte is ignored, and any other low byte changes nothing visible.
- R3: In array-read mode `rdata` equals `arr_rdata` in the same cycle, whatever `addr` holds.
- R4: In configuration-read mode `rdata` depends on the offset o = `addr` − `CFG_BASE`. Offsets 1..4 return factory word k = o−1, which is `FACTORY_ID[16k+15:16k]`. Offsets 5..8 return user word k = o−5. Offset 0 returns the lock word {14'h3FFF, open, 1'b0}, where bit 1 is 1 while the lock is open. Every other offset returns 0000h.
- R5: A write with low byte C0h, made while no program is armed, raises `prog_pending`. The next write is taken as the program operation whatever its data. It clears `prog_pending` and leaves the read mode that was active before the setup.
- R6: A program of user word k stores old AND data, so bits only go from 1 to 0.
- R7: A program at offset 0 with data bit 1 at 0 closes the lock for good. While the lock is closed, a program of a user word leaves all user words unchanged and sets the error flag.
- R8: A program at a factory offset (1..4) is refused: the factory words are unchanged and the error flag is set.
- R9: A program at an undefined offset is refused and sets the error flag.
- R10: The error flag stays set until the next accepted C0h setup write, which clears it. Other commands do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| addr | input | ADDR_W | Address for writes and reads |
| wdata | input | 16 | Command code (low byte) or program data |
| arr_rdata | input | 16 | Word from the memory array, passed through in array-read mode |
| rdata | output | 16 | Read data for `addr` in the current mode |
| cfg_mode | output | 1 | 1 in configuration-read mode |
| prog_pending | output | 1 | 1 between a setup write and its program write |
| prog_err | output | 1 | Sticky flag for a refused program |

## Verification
A write is captured at a rising edge. Its effect on `cfg_mode`, `prog_pending`, `prog_err` and the stored words is therefore visible from the next cycle on. The bench drives each write on a falling edge, lets one rising edge pass, and samples the flags at the following falling edge. `rdata` is a combinational function of `addr`, the mode and the stored words. Each read check therefore sets `addr` and `arr_rdata` and compares one time step later, with no clock edge in between. This makes a program show up on the very next read.

// File: rtl/otp_id_reg.sv
module otp_id_reg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(8'h80),
  parameter logic [63:0] FACTORY_ID = 64'hA5C3_1E0F_7B29_64D8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [15:0]       arr_rdata,
  output logic [15:0]       rdata,
  output logic              cfg_mode,
  output logic              prog_pending,
  output logic              prog_err
);
  localparam int WORDS = 4;
  localparam logic [7:0] CMD_CFG   = 8'h90;
  localparam logic [7:0] CMD_ARR   = 8'hFF;
  localparam logic [7:0] CMD_SETUP = 8'hC0;
  localparam logic [ADDR_W-1:0] OFF_FAC = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_USR = ADDR_W'(1 + WORDS);
  localparam logic [ADDR_W-1:0] OFF_END = ADDR_W'(1 + 2*WORDS);

  logic              cfg_q, pend_q, err_q, lock_open_q;
  logic [63:0]       user_q;
  logic [ADDR_W-1:0] off;
  logic              is_lock, is_fac, is_usr, prog_hit, prog_ok;
  logic [1:0]        widx;

  assign off     = addr - CFG_BASE;
  assign is_lock = (off == '0);
  assign is_fac  = (off >= OFF_FAC) && (off < OFF_USR);
  assign is_usr  = (off >= OFF_USR) && (off < OFF_END);
  assign widx    = is_fac ? 2'(off - OFF_FAC) : 2'(off - OFF_USR);

  assign prog_hit = wr_en && pend_q;
  assign prog_ok  = prog_hit && (is_lock || (is_usr && lock_open_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= 1'b0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (prog_hit) begin
      pend_q <= 1'b0;
      if (!prog_ok) err_q <= 1'b1;
    end else if (wr_en) begin
      case (wdata[7:0])
        CMD_CFG:   cfg_q <= 1'b1;
        CMD_ARR:   cfg_q <= 1'b0;
        CMD_SETUP: begin
          pend_q <= 1'b1;
          err_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lock_open_q <= 1'b1;
    else if (prog_ok && is_lock)
      lock_open_q <= lock_open_q & wdata[1];
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_user
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        user_q[k*16 +: 16] <= 16'hFFFF;
      else if (prog_ok && is_usr && widx == 2'(k))
        user_q[k*16 +: 16] <= user_q[k*16 +: 16] & wdata;
    end
  end

  always_comb begin
    if (!cfg_q)       rdata = arr_rdata;
    else if (is_lock) rdata = {14'h3FFF, lock_open_q, 1'b0};
    else if (is_fac)  rdata = FACTORY_ID[widx*16 +: 16];
    else if (is_usr)  rdata = user_q[widx*16 +: 16];
    else              rdata = 16'h0000;
  end

  assign cfg_mode     = cfg_q;
  assign prog_pending = pend_q;
  assign prog_err     = err_q;
endmodule

// File: rtl/otp_id_reg_chk.sv
module otp_id_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wdata,
  input logic        cfg_mode,
  input logic        prog_pending,
  input logic        prog_err,
  input logic        lock_open_q,
  input logic [63:0] user_q
);
  a_r2_cfg_enter: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !prog_pending && wdata[7:0] == 8'h90 |=> cfg_mode);

  a_r2_arr_enter: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !prog_pending && wdata[7:0] == 8'hFF |=> !cfg_mode);

  a_r5_setup_arms: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !prog_pending && wdata[7:0] == 8'hC0 |=> prog_pending && !prog_err);

  a_r5_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && prog_pending |=> !prog_pending && $stable(cfg_mode));

  a_r6_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (user_q & ~$past(user_q)) == 64'd0);

  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_open_q |=> !lock_open_q);

  a_r7_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_open_q |=> $stable(user_q));

  a_r10_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_err) |-> $past(wr_en && prog_pending));
endmodule

bind otp_id_reg otp_id_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
  .cfg_mode(cfg_mode), .prog_pending(prog_pending), .prog_err(prog_err),
  .lock_open_q(lock_open_q), .user_q(user_q)
);

// File: tb/otp_id_reg_bench.sv
module otp_id_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] FID = 64'h3C1D_9E07_B4A2_58F6;
  localparam logic [7:0]  BASE = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0, arr_rdata = '0, rdata;
  logic cfg_mode, prog_pending, prog_err;

  int n_chk = 0, n_err = 0;
  bit m_cfg, m_pend, m_err, m_open;
  logic [63:0] m_user;

  otp_id_reg #(.ADDR_W(8), .CFG_BASE(BASE), .FACTORY_ID(FID)) u_otp_id_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .arr_rdata(arr_rdata), .rdata(rdata), .cfg_mode(cfg_mode),
    .prog_pending(prog_pending), .prog_err(prog_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_rd(logic [7:0] a, logic [15:0] arr);
    logic [7:0] o;
    o = a - BASE;
    if (!m_cfg) return arr;
    if (o == 8'd0) return {14'h3FFF, m_open, 1'b0};
    if (o >= 8'd1 && o <= 8'd4) return FID[(o-8'd1)*16 +: 16];
    if (o >= 8'd5 && o <= 8'd8) return m_user[(o-8'd5)*16 +: 16];
    return 16'h0000;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic flags(string tag);
    chk(tag, {61'd0, cfg_mode, prog_pending, prog_err}, {61'd0, m_cfg, m_pend, m_err});
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    logic [7:0] o;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    o = a - BASE;
    if (m_pend) begin
      m_pend = 1'b0;
      if (o == 8'd0) m_open = m_open & d[1];
      else if (o >= 8'd5 && o <= 8'd8 && m_open)
        m_user[(o-8'd5)*16 +: 16] = m_user[(o-8'd5)*16 +: 16] & d;
      else m_err = 1'b1;
    end else begin
      case (d[7:0])
        8'h90: m_cfg = 1'b1;
        8'hFF: m_cfg = 1'b0;
        8'hC0: begin m_pend = 1'b1; m_err = 1'b0; end
        default: ;
      endcase
    end
  endtask

  task automatic rd(string tag, logic [7:0] a);
    addr = a; arr_rdata = 16'($urandom);
    #1;
    chk(tag, {48'd0, rdata}, {48'd0, exp_rd(a, arr_rdata)});
  endtask

  task automatic prog(logic [7:0] o, logic [15:0] d);
    wr(8'h00, 16'h00C0);
    wr(BASE + o, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] a;
    int sel;
    void'($urandom(32'd1234));
    m_cfg = 0; m_pend = 0; m_err = 0; m_open = 1; m_user = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    flags("R1 reset flags");
    rd("R3 array passthrough", 8'h85);
    rd("R3 array passthrough cfg addr", BASE);
    wr(8'h00, 16'h1290);
    flags("R2 upper byte ignored");
    for (int k = 0; k < 4; k++) rd("R1 user blank", BASE + 8'(5 + k));
    rd("R1 lock open", BASE);
    for (int k = 0; k < 4; k++) rd("R4 factory word", BASE + 8'(1 + k));
    rd("R4 undefined offset", BASE + 8'd9);
    rd("R4 undefined low", 8'h10);
    wr(8'h00, 16'h0055);
    flags("R2 unknown code ignored");
    wr(8'h00, 16'h00C0);
    flags("R5 setup arms");
    wr(BASE + 8'd6, 16'h00FF);
    flags("R5 program disarms, stays cfg");
    rd("R6 programmed word", BASE + 8'd6);
    prog(8'd6, 16'hF0F0);
    rd("R6 AND only", BASE + 8'd6);
    prog(8'd2, 16'h0000);
    flags("R8 factory refused err");
    rd("R8 factory unchanged", BASE + 8'd2);
    wr(8'h00, 16'h00FF);
    flags("R10 err sticky across FFh");
    rd("R3 array mode again", BASE + 8'd2);
    wr(8'h00, 16'h00C0);
    flags("R10 setup clears err");
    wr(8'h42, 16'h0000);
    flags("R9 undefined refused, R5 mode kept");
    wr(8'h00, 16'h0090);
    prog(8'd0, 16'hFFFD);
    rd("R7 lock word closed", BASE);
    prog(8'd7, 16'h0000);
    flags("R7 locked user refused");
    rd("R7 user unchanged", BASE + 8'd7);
    prog(8'd0, 16'hFFFF);
    rd("R7 lock stays closed", BASE);

    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    m_cfg = 0; m_pend = 0; m_err = 0; m_open = 1; m_user = '1;
    flags("R1 reset again");
    for (int i = 0; i < 600; i++) begin
      sel = int'($urandom_range(0, 9));
      a = BASE + 8'($urandom_range(0, 10)) - 8'd1;
      case (sel)
        0, 1: wr(8'h00, {8'($urandom), 8'h90});
        2:    wr(8'h00, {8'($urandom), 8'hFF});
        3, 4: wr(8'h00, 16'h00C0);
        5:    wr(a, (m_pend || $urandom_range(0, 3) != 0) ? 16'($urandom) : 16'h0033);
        default: wr(a, 16'($urandom) | 16'h0002);
      endcase
      flags("R2/R5/R10 random flags");
      rd("R4/R6 random read", a);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule